// File: doc/BRIEF.md
# Competitive Snooping Line Controller

This block tracks the coherence state of a small array of cache line entries under a hybrid snooping protocol. Lines are kept up to date by bus updates from other caches for as long as the local processor keeps using them. Each line holds a countdown counter. A fill or a local access sets the counter to a threshold. Each update snooped from another cache for that line counts it down. When the count runs out, the line drops to Invalid, and the protocol has moved from updating to invalidating for that block.

A local write to a Shared line issues a bus update. When no other cache raises the shared response to that update, the line takes ownership as Modified, and later writes to it go out on no bus. A build-time option selects one of two policies. In the plain policy a line is invalidated as soon as its own count reaches zero. In the consensus policy a line waits at zero until an input reports that every cache's counter for the block is zero. Data movement, arbitration and memory lie outside this block.

Top module: `csnp_ctrl`

## Requirements
- R1: After reset, every line is Invalid (code 0), the bus command output is none (code 0) and the error flag is low.
- R2: A fill to a line index makes that line Shared (code 1) with its tag taken from the fill, and sets the line's counter to THRESH. A fill takes priority over any other event on that line in the same cycle.
- R3: A snooped update whose tag matches a valid Shared line counts that line's counter down by one. The line stays Shared while the new count is above zero.
- R4: A local read or write to a valid line sets its counter back to THRESH.
- R5: With ALL_ZERO_MODE=0, a snooped update that brings a Shared line's counter to zero makes the line Invalid.
- R6: With ALL_ZERO_MODE=1, a Shared line whose count reaches zero stays Shared. It goes Invalid only on a matching snooped update that arrives while snoop_all_zero is high. The counter saturates at zero and does not wrap.
- R7: A shared response for a Shared line with resp_shared low makes the line Modified (code 2). With resp_shared high, the line stays Shared.
- R8: One cycle after a local access, bus_cmd_o reports the command for it. The codes are: 1 for a write to a Shared line, 2 for a read to an Invalid line, 3 for a write to an Invalid line, and 0 for any other access. Without a local access the code is 0.
- R9: A snooped update that matches a Modified line sets a sticky error flag and leaves the line Modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_valid | input | 1 | Block fill event |
| fill_idx | input | IDX_W | Line index being filled |
| fill_tag | input | TAG_W | Tag of the filled block |
| cpu_valid | input | 1 | Local processor access |
| cpu_write | input | 1 | Access is a write |
| cpu_idx | input | IDX_W | Line index of the access |
| snoop_valid | input | 1 | Snooped bus update from another cache |
| snoop_tag | input | TAG_W | Tag of the snooped update |
| snoop_all_zero | input | 1 | All caches' counters for the snooped block are zero |
| resp_valid | input | 1 | Shared response sample for an update issued by this cache |
| resp_idx | input | IDX_W | Line index the response belongs to |
| resp_shared | input | 1 | Another sharer exists |
| line_state_o | output | 2*NUM_LINES | Per-line state, 2 bits per line, line 0 in the low bits |
| bus_cmd_o | output | 2 | Bus command for the last local access |
| bus_idx_o | output | IDX_W | Line index of that command |
| err_o | output | 1 | Sticky protocol error |

## Verification
The bench builds two instances with four lines, 8-bit tags and a threshold of 3. One instance uses the plain policy and the other the consensus policy, and both receive the same stimulus. The small threshold lets a short run of updates reach the zero count, and lets a local read that resets the counter mid-run show a visible change in when invalidation happens. Running the policies side by side shows their split at the zero count. It also shows that extra updates at zero do not wrap the counter: the consensus line still drops on the first update that arrives with the all-zero input high.

// File: rtl/csnp_pkg.sv
// Shared encodings for the competitive snooping line controller.
package csnp_pkg;
    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_MOD = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE   = 2'd0,
        BC_UPDATE = 2'd1,
        BC_READ   = 2'd2,
        BC_READX  = 2'd3
    } bus_cmd_e;
endpackage

// File: rtl/csnp_line.sv
// One line entry: state, tag and saturating countdown counter.
// Assumes the parent resolves index matches for fill, response and
// local access; the snoop tag match is done here.
module csnp_line
    import csnp_pkg::*;
#(
    parameter int TAG_W         = 8,
    parameter int THRESH        = 3,
    parameter bit ALL_ZERO_MODE = 1'b0,
    parameter int CNT_W         = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_hit,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             snoop_valid,
    input  logic [TAG_W-1:0] snoop_tag,
    input  logic             all_zero,
    input  logic             resp_solo,
    input  logic             cpu_touch,
    output line_st_e         state,
    output logic             snoop_on_mod
);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(THRESH);

    line_st_e         st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [TAG_W-1:0] tag_q;
    logic             snoop_hit;
    logic [CNT_W-1:0] cnt_dec;
    logic             drop;

    // Tag match of a snooped update against this valid line.
    assign snoop_hit = snoop_valid && (st_q != LS_INV) && (tag_q == snoop_tag);
    // Saturating decrement; never below zero.
    assign cnt_dec   = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
    // Invalidate decision depends on the selected policy.
    assign drop      = (cnt_dec == '0) && (!ALL_ZERO_MODE || all_zero);

    // State, counter and tag update with priority fill > snoop > response > access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= LS_INV;
            cnt_q <= '0;
            tag_q <= '0;
        end else if (fill_hit) begin
            st_q  <= LS_SHR;
            cnt_q <= RELOAD;
            tag_q <= fill_tag;
        end else if (snoop_hit) begin
            if (st_q == LS_SHR) begin
                cnt_q <= cnt_dec;
                if (drop) st_q <= LS_INV;
            end
        end else if (resp_solo && (st_q == LS_SHR)) begin
            st_q  <= LS_MOD;
            cnt_q <= RELOAD;
        end else if (cpu_touch && (st_q != LS_INV)) begin
            cnt_q <= RELOAD;
        end
    end

    assign state        = st_q;
    assign snoop_on_mod = snoop_hit && (st_q == LS_MOD);
endmodule

// File: rtl/csnp_cmd.sv
// Bus command generator: registers the command a local access needs,
// given the current state of the addressed line.
module csnp_cmd
    import csnp_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_valid,
    input  logic             cpu_write,
    input  logic [IDX_W-1:0] cpu_idx,
    input  line_st_e         cur_state,
    output bus_cmd_e         cmd,
    output logic [IDX_W-1:0] cmd_idx
);
    // One-cycle registered command decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd     <= BC_NONE;
            cmd_idx <= '0;
        end else if (cpu_valid) begin
            cmd_idx <= cpu_idx;
            case (cur_state)
                LS_SHR:  cmd <= cpu_write ? BC_UPDATE : BC_NONE;
                LS_INV:  cmd <= cpu_write ? BC_READX : BC_READ;
                default: cmd <= BC_NONE;
            endcase
        end else begin
            cmd <= BC_NONE;
        end
    end
endmodule

// File: rtl/csnp_ctrl.sv
// Top: array of line entries under a competitive update/invalidate
// policy, plus bus command generation and a sticky error flag.
// Assumes at most one valid line matches a snooped tag.
module csnp_ctrl
    import csnp_pkg::*;
#(
    parameter int NUM_LINES     = 4,
    parameter int TAG_W         = 8,
    parameter int THRESH        = 3,
    parameter bit ALL_ZERO_MODE = 1'b0,
    parameter int IDX_W         = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fill_valid,
    input  logic [IDX_W-1:0]       fill_idx,
    input  logic [TAG_W-1:0]       fill_tag,
    input  logic                   cpu_valid,
    input  logic                   cpu_write,
    input  logic [IDX_W-1:0]       cpu_idx,
    input  logic                   snoop_valid,
    input  logic [TAG_W-1:0]       snoop_tag,
    input  logic                   snoop_all_zero,
    input  logic                   resp_valid,
    input  logic [IDX_W-1:0]       resp_idx,
    input  logic                   resp_shared,
    output logic [2*NUM_LINES-1:0] line_state_o,
    output logic [1:0]             bus_cmd_o,
    output logic [IDX_W-1:0]       bus_idx_o,
    output logic                   err_o
);
    localparam int CNT_W = (THRESH > 1) ? $clog2(THRESH + 1) : 1;

    line_st_e               st_w [NUM_LINES];
    logic [NUM_LINES-1:0]   mod_hit;
    line_st_e               cpu_state;
    bus_cmd_e               cmd_w;
    logic                   err_q;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        csnp_line #(
            .TAG_W(TAG_W), .THRESH(THRESH),
            .ALL_ZERO_MODE(ALL_ZERO_MODE), .CNT_W(CNT_W)
        ) u_line (
            .clk(clk),
            .rst_n(rst_n),
            .fill_hit(fill_valid && (fill_idx == IDX_W'(i))),
            .fill_tag(fill_tag),
            .snoop_valid(snoop_valid),
            .snoop_tag(snoop_tag),
            .all_zero(snoop_all_zero),
            .resp_solo(resp_valid && !resp_shared && (resp_idx == IDX_W'(i))),
            .cpu_touch(cpu_valid && (cpu_idx == IDX_W'(i))),
            .state(st_w[i]),
            .snoop_on_mod(mod_hit[i])
        );
        assign line_state_o[2*i +: 2] = st_w[i];
    end

    // State of the line addressed by the local access.
    assign cpu_state = st_w[cpu_idx];

    csnp_cmd #(.IDX_W(IDX_W)) u_cmd (
        .clk(clk),
        .rst_n(rst_n),
        .cpu_valid(cpu_valid),
        .cpu_write(cpu_write),
        .cpu_idx(cpu_idx),
        .cur_state(cpu_state),
        .cmd(cmd_w),
        .cmd_idx(bus_idx_o)
    );
    assign bus_cmd_o = cmd_w;

    // Sticky protocol error on a snooped update hitting a Modified line.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else if (|mod_hit) err_q <= 1'b1;
    end
    assign err_o = err_q;
endmodule

// File: rtl/csnp_ctrl_chk.sv
// Property checker for csnp_ctrl, attached to every instance by bind.
module csnp_ctrl_chk #(
    parameter int NUM_LINES = 4,
    parameter int IDX_W     = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   fill_valid,
    input logic [IDX_W-1:0]       fill_idx,
    input logic                   cpu_valid,
    input logic                   cpu_write,
    input logic [IDX_W-1:0]       cpu_idx,
    input logic                   snoop_valid,
    input logic                   resp_valid,
    input logic [IDX_W-1:0]       resp_idx,
    input logic                   resp_shared,
    input logic [2*NUM_LINES-1:0] line_state_o,
    input logic [1:0]             bus_cmd_o,
    input logic                   err_o
);
    // R9: error flag never clears once set.
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    // R9: error rises only after a snooped update.
    p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $past(snoop_valid));

    // R2: filled line is Shared the next cycle.
    p_fill_shared_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> (line_state_o[2*$past(fill_idx) +: 2] == 2'd1));

    // R8: write to a Shared line yields an update command.
    p_write_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_write && line_state_o[2*cpu_idx +: 2] == 2'd1)
        |=> (bus_cmd_o == 2'd1));

    // R8: no local access means no command.
    p_idle_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_valid |=> (bus_cmd_o == 2'd0));

    // R7: solo response on a Shared line makes it Modified.
    p_solo_mod_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_shared && !snoop_valid && !fill_valid &&
         line_state_o[2*resp_idx +: 2] == 2'd1)
        |=> (line_state_o[2*$past(resp_idx) +: 2] == 2'd2));

    // R5: a Shared line only goes Invalid after a snooped update.
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
        p_drop_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (line_state_o[2*i +: 2] == 2'd1 && !snoop_valid)
            |=> (line_state_o[2*i +: 2] != 2'd0));
    end
endmodule

bind csnp_ctrl csnp_ctrl_chk #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_idx(fill_idx),
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_idx(cpu_idx),
    .snoop_valid(snoop_valid), .resp_valid(resp_valid), .resp_idx(resp_idx),
    .resp_shared(resp_shared), .line_state_o(line_state_o),
    .bus_cmd_o(bus_cmd_o), .err_o(err_o)
);

// File: tb/csnp_ctrl_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: two instances (plain and consensus policy) share stimulus.
module csnp_ctrl_tb_top;
    localparam int NL = 4;
    localparam int TW = 8;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fill_valid = 0, cpu_valid = 0, cpu_write = 0, snoop_valid = 0;
    logic snoop_all_zero = 0, resp_valid = 0, resp_shared = 0;
    logic [IW-1:0] fill_idx = '0, cpu_idx = '0, resp_idx = '0;
    logic [TW-1:0] fill_tag = '0, snoop_tag = '0;
    logic [2*NL-1:0] st_p, st_v;
    logic [1:0] cmd_p, cmd_v;
    logic [IW-1:0] bidx_p, bidx_v;
    logic err_p, err_v;

    always #4 clk = ~clk;

    csnp_ctrl #(.NUM_LINES(NL), .TAG_W(TW), .THRESH(3), .ALL_ZERO_MODE(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_idx(fill_idx),
        .fill_tag(fill_tag), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
        .cpu_idx(cpu_idx), .snoop_valid(snoop_valid), .snoop_tag(snoop_tag),
        .snoop_all_zero(snoop_all_zero), .resp_valid(resp_valid),
        .resp_idx(resp_idx), .resp_shared(resp_shared), .line_state_o(st_p),
        .bus_cmd_o(cmd_p), .bus_idx_o(bidx_p), .err_o(err_p));

    csnp_ctrl #(.NUM_LINES(NL), .TAG_W(TW), .THRESH(3), .ALL_ZERO_MODE(1'b1)) dut_v (
        .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_idx(fill_idx),
        .fill_tag(fill_tag), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
        .cpu_idx(cpu_idx), .snoop_valid(snoop_valid), .snoop_tag(snoop_tag),
        .snoop_all_zero(snoop_all_zero), .resp_valid(resp_valid),
        .resp_idx(resp_idx), .resp_shared(resp_shared), .line_state_o(st_v),
        .bus_cmd_o(cmd_v), .bus_idx_o(bidx_v), .err_o(err_v));

    // kind: 0 line state, 1 command, 2 error flag, 3 command index
    typedef struct {
        int    dut;
        int    kind;
        int    idx;
        int    exp;
        string req;
    } item_t;

    item_t q[$];
    event  chk_ev;
    int    n_chk = 0;
    int    n_fail = 0;

    // Driver side: queue an expectation.
    task automatic expect_v(input int dut, input int kind, input int idx,
                            input int exp, input string req);
        item_t it;
        it.dut = dut; it.kind = kind; it.idx = idx; it.exp = exp; it.req = req;
        q.push_back(it);
    endtask

    // Hand the queued expectations to the monitor.
    task automatic flush();
        -> chk_ev;
        #1;
    endtask

    // Monitor: pop and compare against the outputs.
    always @(chk_ev) begin
        while (q.size() > 0) begin
            item_t it;
            int act;
            it = q.pop_front();
            case (it.kind)
                0: act = (it.dut == 0) ? int'(st_p[2*it.idx +: 2]) : int'(st_v[2*it.idx +: 2]);
                1: act = (it.dut == 0) ? int'(cmd_p) : int'(cmd_v);
                2: act = (it.dut == 0) ? int'(err_p) : int'(err_v);
                default: act = (it.dut == 0) ? int'(bidx_p) : int'(bidx_v);
            endcase
            n_chk++;
            if (act != it.exp) begin
                n_fail++;
                $display("FAIL %s dut%0d kind%0d idx%0d: actual %0d expected %0d",
                         it.req, it.dut, it.kind, it.idx, act, it.exp);
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        fill_valid = 0; cpu_valid = 0; cpu_write = 0; snoop_valid = 0;
        snoop_all_zero = 0; resp_valid = 0; resp_shared = 0;
    endtask

    task automatic do_fill(input int idx, input int tag);
        fill_valid = 1; fill_idx = IW'(idx); fill_tag = TW'(tag);
        cyc(); idle();
    endtask

    task automatic do_snoop(input int tag, input logic az);
        snoop_valid = 1; snoop_tag = TW'(tag); snoop_all_zero = az;
        cyc(); idle();
    endtask

    task automatic do_cpu(input int idx, input logic wr);
        cpu_valid = 1; cpu_idx = IW'(idx); cpu_write = wr;
        cyc(); idle();
    endtask

    task automatic do_resp(input int idx, input logic sh);
        resp_valid = 1; resp_idx = IW'(idx); resp_shared = sh;
        cyc(); idle();
    endtask

    task automatic both_state(input int idx, input int exp, input string req);
        expect_v(0, 0, idx, exp, req);
        expect_v(1, 0, idx, exp, req);
    endtask

    task automatic run();
        @(negedge clk);
        repeat (3) cyc();
        // R1 reset state
        for (int i = 0; i < NL; i++) both_state(i, 0, "R1");
        expect_v(0, 1, 0, 0, "R1"); expect_v(1, 1, 0, 0, "R1");
        expect_v(0, 2, 0, 0, "R1"); expect_v(1, 2, 0, 0, "R1");
        flush();
        rst_n = 1;
        cyc();

        // R2 fills
        do_fill(0, 'h11);
        do_fill(1, 'h22);
        do_fill(2, 'h33);
        for (int i = 0; i < 3; i++) both_state(i, 1, "R2");
        both_state(3, 0, "R2");
        flush();

        // R3 two updates leave line 0 Shared
        do_snoop('h11, 0);
        do_snoop('h11, 0);
        both_state(0, 1, "R3");
        flush();
        // R5 / R6 third update reaches zero
        do_snoop('h11, 0);
        expect_v(0, 0, 0, 0, "R5");
        expect_v(1, 0, 0, 1, "R6");
        flush();
        // R6 extra updates at zero without consensus: no wrap, still Shared
        do_snoop('h11, 0);
        do_snoop('h11, 0);
        expect_v(1, 0, 0, 1, "R6");
        flush();
        // R6 consensus signal drops it on the next update
        do_snoop('h11, 1);
        expect_v(1, 0, 0, 0, "R6");
        expect_v(0, 0, 0, 0, "R5");
        flush();

        // R4 reload on local read mid-run
        do_snoop('h22, 0);
        do_snoop('h22, 0);
        do_cpu(1, 0);
        expect_v(0, 1, 0, 0, "R8");
        flush();
        do_snoop('h22, 0);
        do_snoop('h22, 0);
        both_state(1, 1, "R4");
        flush();
        do_snoop('h22, 0);
        expect_v(0, 0, 1, 0, "R5");
        expect_v(1, 0, 1, 1, "R6");
        flush();

        // R8 write to Shared issues update
        do_cpu(2, 1);
        expect_v(0, 1, 0, 1, "R8"); expect_v(1, 1, 0, 1, "R8");
        expect_v(0, 3, 0, 2, "R8");
        flush();
        // R7 shared response keeps Shared, solo response gives Modified
        do_resp(2, 1);
        both_state(2, 1, "R7");
        expect_v(0, 1, 0, 0, "R8");
        flush();
        do_resp(2, 0);
        both_state(2, 2, "R7");
        flush();
        // R8 write to Modified: no command
        do_cpu(2, 1);
        expect_v(0, 1, 0, 0, "R8"); expect_v(1, 1, 0, 0, "R8");
        expect_v(0, 2, 0, 0, "R9");
        flush();
        // R9 snoop hits Modified
        do_snoop('h33, 0);
        expect_v(0, 2, 0, 1, "R9"); expect_v(1, 2, 0, 1, "R9");
        both_state(2, 2, "R9");
        flush();
        cyc(); cyc();
        expect_v(0, 2, 0, 1, "R9"); expect_v(1, 2, 0, 1, "R9");
        flush();

        // R8 misses on Invalid line 3
        do_cpu(3, 0);
        expect_v(0, 1, 0, 2, "R8");
        expect_v(0, 3, 0, 3, "R8");
        flush();
        do_cpu(3, 1);
        expect_v(0, 1, 0, 3, "R8"); expect_v(1, 1, 0, 3, "R8");
        both_state(3, 0, "R8");
        flush();
        // R2 refill of an Invalid line with a snoop in the same cycle: fill wins
        fill_valid = 1; fill_idx = 2'd0; fill_tag = 8'h44;
        snoop_valid = 1; snoop_tag = 8'h44;
        cyc(); idle();
        both_state(0, 1, "R2");
        flush();
    endtask

    initial begin
        bit wd = 0;
        idle();
        fork
            run();
            begin
                repeat (5000) @(posedge clk);
                wd = 1;
            end
        join_any
        disable fork;
        if (wd) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule